// File: doc/BRIEF.md
# Mode-Dependent Address/GPIO Port Controller

This block controls an eight-pin port that serves either as general-purpose I/O or as part of the external address bus. A three-bit operating mode, together with a per-pin direction bit, decides which function each pin has. In the two external-bus modes every pin carries an address bit. In the mixed mode the direction bit chooses between address output and input. In single-chip operation the direction bit chooses between driving the data register and input. The block drives a value, an output enable and a pull-up enable for each pin. The pad and the pull-up device itself sit outside the block.

Software reaches four byte registers through a simple register bus that decodes the low 16 address bits. The direction register accepts writes only. The data and pull-up registers can be written and read back. The pin-state register returns the synchronized pin levels and ignores writes. Read data appears on `bus_rdata` one cycle after the read is presented and returns to zero in the following idle cycle.

The block also handles the low-power and reset states. Hardware standby and power-on reset clear every register. A manual reset leaves the direction register untouched. In software standby, address pins either hold the address captured when standby was entered or stop driving, as a keep input selects.

Top module: `addr_gpio_port`

## Requirements
- R1: A bus write (`bus_sel`=1, `bus_wr`=1) to 0xFE3B loads the direction register, to 0xFF0B the data register and to 0xFE42 the pull-up register, all at the next clock edge; bit n of each register governs pin n. Reads of 0xFF0B and 0xFE42 return the stored byte on `bus_rdata` one cycle after the read.
- R2: A read of the direction register (0xFE3B) returns 0xFF. A read of any unmapped address returns 0x00, and `bus_rdata` is 0x00 in a cycle that follows no read.
- R3: A read of 0xFFBB returns `pin_in` after a two-flip-flop synchronizer. A write to 0xFFBB changes no register.
- R4: Power-on reset (`por_n`=0, asynchronous) clears the direction, data and pull-up registers to 0x00 and `bus_rdata` to 0x00.
- R5: Manual reset (`mrst_n`=0, sampled at the clock edge) clears the data and pull-up registers and leaves the direction register unchanged.
- R6: In modes 4 and 5 every pin is enabled and drives its `addr_in` bit, whatever the direction register holds.
- R7: In mode 6 a pin whose direction bit is 1 is enabled and drives its `addr_in` bit, and a pin whose direction bit is 0 is an input (enable 0, value 0).
- R8: In mode 7 and in modes 0 to 3, a pin whose direction bit is 1 is enabled and drives its data-register bit, and a pin whose direction bit is 0 is an input.
- R9: `pull_en[n]` is 1 only when pull-up bit n is 1 and pin n is acting as an input. It is 0 whenever the pin drives or is an address pin.
- R10: While `hw_stby`=1 every `pin_oe` and `pull_en` bit is 0, all registers clear at the next edge, and bus writes are ignored.
- R11: Software standby starts at the edge that samples `sw_stby`=1 and ends at the edge that samples it 0. While it lasts, address pins drive the `addr_in` value captured at the entry edge if `keep_addr`=1, or are disabled if `keep_addr`=0. GPIO pins and the direction register are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| hw_stby | input | 1 | Hardware standby, active high |
| sw_stby | input | 1 | Software standby request, level |
| keep_addr | input | 1 | In software standby: 1 holds address pins, 0 floats them |
| mode | input | 3 | Operating mode |
| bus_sel | input | 1 | Register bus cycle valid |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 16 | Low 16 address bits |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle latency |
| addr_in | input | 8 | Address bits for this port's pins |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| pull_en | output | 8 | Pull-up enables |

## Verification
The hardest case to reach is the held address in software standby. It must be shown to be the value captured at the entry edge and not a later value. To do this, the bench moves `addr_in` immediately after the entry edge and checks that the address pins keep the old value. It then changes `keep_addr` while standby is still active to show the pins going to high impedance, and confirms that at the exit edge the pins drive the live address again with the direction register intact. Two other checks need careful stimulus: that a manual reset keeps the direction register, and that a hardware standby suppresses a write made during it. Since the direction register cannot be read, the bench observes it through the output enables.

// File: rtl/agp_pkg.sv
package agp_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 16;
    localparam int MODE_W = 3;

    localparam logic [ADDR_W-1:0] A_DIR  = 16'hFE3B;
    localparam logic [ADDR_W-1:0] A_DATA = 16'hFF0B;
    localparam logic [ADDR_W-1:0] A_PIN  = 16'hFFBB;
    localparam logic [ADDR_W-1:0] A_PULL = 16'hFE42;

    localparam logic [MODE_W-1:0] M_EXT_A = 3'd4;
    localparam logic [MODE_W-1:0] M_EXT_B = 3'd5;
    localparam logic [MODE_W-1:0] M_MIXED = 3'd6;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] dat;
        logic [PORT_W-1:0] pull;
        logic [PORT_W-1:0] hold;
        logic [PORT_W-1:0] rdata;
        logic              stby;
    } port_state_t;
endpackage

// File: rtl/agp_sync.sv
module agp_sync #(
    parameter int W = agp_pkg::PORT_W
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = async_in;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_out = s2_q;
endmodule

// File: rtl/agp_regbank.sv
module agp_regbank
    import agp_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic [PORT_W-1:0] pin_sync,
    input  logic [PORT_W-1:0] addr_in,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] dat_q,
    output logic [PORT_W-1:0] pull_q,
    output logic [PORT_W-1:0] hold_q,
    output logic              stby_q,
    output logic [PORT_W-1:0] rdata_q
);
    port_state_t st_d, st_q;
    logic        wr_hit, rd_hit;

    always_comb begin
        wr_hit = bus_sel && bus_wr;
        rd_hit = bus_sel && !bus_wr;
        st_d = st_q;
        st_d.rdata = '0;
        if (hw_stby) begin
            st_d = '0;
        end else if (!mrst_n) begin
            st_d.dat  = '0;
            st_d.pull = '0;
            st_d.hold = '0;
            st_d.stby = 1'b0;
        end else begin
            if (wr_hit) begin
                case (bus_addr)
                    A_DIR:   st_d.dir  = bus_wdata;
                    A_DATA:  st_d.dat  = bus_wdata;
                    A_PULL:  st_d.pull = bus_wdata;
                    default: ;
                endcase
            end
            if (rd_hit) begin
                case (bus_addr)
                    A_DIR:   st_d.rdata = '1;
                    A_DATA:  st_d.rdata = st_q.dat;
                    A_PULL:  st_d.rdata = st_q.pull;
                    A_PIN:   st_d.rdata = pin_sync;
                    default: st_d.rdata = '0;
                endcase
            end
            if (sw_stby && !st_q.stby) begin
                st_d.hold = addr_in;
            end
            st_d.stby = sw_stby;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_q   = st_q.dir;
    assign dat_q   = st_q.dat;
    assign pull_q  = st_q.pull;
    assign hold_q  = st_q.hold;
    assign stby_q  = st_q.stby;
    assign rdata_q = st_q.rdata;

    // R5: manual reset leaves direction alone
    a_r5_dir_survives_mrst: assert property (@(posedge clk) disable iff (!por_n)
        (!mrst_n && !hw_stby) |=> $stable(dir_q));
    // R10: hardware standby empties every register
    a_r10_hwstby_clears: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |=> (dir_q == '0 && dat_q == '0 && pull_q == '0 && stby_q == 1'b0));
    // R11: captured address frozen for the rest of standby
    a_r11_hold_frozen: assert property (@(posedge clk) disable iff (!por_n)
        (stby_q && sw_stby && mrst_n && !hw_stby) |=> $stable(hold_q));
    // R2: direction register reads as all ones
    a_r2_dir_reads_ones: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && !bus_wr && bus_addr == A_DIR && mrst_n && !hw_stby)
        |=> rdata_q == '1);
endmodule

// File: rtl/agp_pin_mux.sv
module agp_pin_mux
    import agp_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              hw_stby,
    input  logic              stby_q,
    input  logic              keep_addr,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] dat_q,
    input  logic [PORT_W-1:0] pull_q,
    input  logic [PORT_W-1:0] hold_q,
    input  logic [PORT_W-1:0] addr_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pull_en
);
    logic ext_mode, mixed_mode;

    always_comb begin
        ext_mode   = (mode == M_EXT_A) || (mode == M_EXT_B);
        mixed_mode = (mode == M_MIXED);
    end

    for (genvar n = 0; n < PORT_W; n++) begin : g_pin
        logic is_addr, is_gpio_out, addr_val, addr_drv;

        always_comb begin
            is_addr     = ext_mode || (mixed_mode && dir_q[n]);
            is_gpio_out = !is_addr && dir_q[n];
            addr_val    = stby_q ? hold_q[n] : addr_in[n];
            addr_drv    = !stby_q || keep_addr;
            if (hw_stby) begin
                pin_oe[n]  = 1'b0;
                pin_out[n] = 1'b0;
                pull_en[n] = 1'b0;
            end else if (is_addr) begin
                pin_oe[n]  = addr_drv;
                pin_out[n] = addr_drv && addr_val;
                pull_en[n] = 1'b0;
            end else if (is_gpio_out) begin
                pin_oe[n]  = 1'b1;
                pin_out[n] = dat_q[n];
                pull_en[n] = 1'b0;
            end else begin
                pin_oe[n]  = 1'b0;
                pin_out[n] = 1'b0;
                pull_en[n] = pull_q[n];
            end
        end
    end

    // R9: never a pull-up on a driven pin
    a_r9_no_pull_on_driver: assert property (@(posedge clk) disable iff (!por_n)
        (pin_oe & pull_en) == '0);
    // R10: hardware standby silences the pins
    a_r10_hwstby_no_drive: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |-> (pin_oe == '0 && pull_en == '0));
    // R6: bus modes put the live address on every pin
    a_r6_ext_all_addr: assert property (@(posedge clk) disable iff (!por_n)
        (ext_mode && !stby_q && !hw_stby) |-> (pin_oe == '1 && pin_out == addr_in));
endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port
    import agp_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              keep_addr,
    input  logic [MODE_W-1:0] mode,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] addr_in,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pull_en
);
    logic [PORT_W-1:0] pin_sync, dir_q, dat_q, pull_q, hold_q;
    logic              stby_q;

    agp_sync #(.W(PORT_W)) u_sync (
        .clk(clk), .por_n(por_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    agp_regbank u_regs (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_sync(pin_sync),
        .addr_in(addr_in), .dir_q(dir_q), .dat_q(dat_q), .pull_q(pull_q),
        .hold_q(hold_q), .stby_q(stby_q), .rdata_q(bus_rdata)
    );

    agp_pin_mux u_mux (
        .clk(clk), .por_n(por_n), .mode(mode), .hw_stby(hw_stby),
        .stby_q(stby_q), .keep_addr(keep_addr), .dir_q(dir_q),
        .dat_q(dat_q), .pull_q(pull_q), .hold_q(hold_q), .addr_in(addr_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en)
    );
endmodule

// File: tb/tb_addr_gpio_port.sv
`timescale 1ns/1ps
module tb_addr_gpio_port;
    logic        clk = 1'b0;
    logic        por_n, mrst_n, hw_stby, sw_stby, keep_addr;
    logic [2:0]  mode;
    logic        bus_sel, bus_wr;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata, addr_in, pin_in, pin_out, pin_oe, pull_en;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    addr_gpio_port dut (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .keep_addr(keep_addr), .mode(mode),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .addr_in(addr_in),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en)
    );

    // {mode, dir, data, pull, addr, exp_oe, exp_out, exp_pull}
    localparam logic [63:0] VEC [0:6] = '{
        64'h04_00_AA_FF_5A_FF_5A_00,   // R6 mode 4
        64'h05_F0_00_0F_C3_FF_C3_00,   // R6 mode 5
        64'h06_F0_FF_FF_3C_F0_30_0F,   // R7 upper pins address
        64'h06_0F_00_33_A5_0F_05_30,   // R7 lower pins address
        64'h07_CC_A5_FF_FF_CC_84_33,   // R8 mode 7 mixed directions
        64'h07_00_FF_81_00_00_00_81,   // R8 all inputs, R9 pulls
        64'h02_FF_69_FF_00_FF_69_00    // R8 low mode acts single-chip
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr8(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_rd8(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        por_n = 1'b0; mrst_n = 1'b1; hw_stby = 1'b0; sw_stby = 1'b0;
        keep_addr = 1'b1; mode = 3'd7; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0; addr_in = '0; pin_in = '0;
        #1;
        chk("R4", "rdata in reset", bus_rdata, 8'h00);
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R4", "oe after reset", pin_oe, 8'h00);
        chk("R4", "pull after reset", pull_en, 8'h00);
        bus_rd8(16'hFF0B, rd); chk("R4", "data reg reset", rd, 8'h00);
        bus_rd8(16'hFE42, rd); chk("R4", "pull reg reset", rd, 8'h00);

        // Vector table: R6 R7 R8 R9
        for (int i = 0; i < 7; i++) begin
            logic [63:0] v;
            string tag;
            v = VEC[i];
            bus_wr8(16'hFE3B, v[55:48]);
            bus_wr8(16'hFF0B, v[47:40]);
            bus_wr8(16'hFE42, v[39:32]);
            @(negedge clk);
            mode = v[58:56]; addr_in = v[31:24];
            #1;
            tag = (v[58:56] == 3'd4 || v[58:56] == 3'd5) ? "R6" :
                  (v[58:56] == 3'd6) ? "R7" : "R8";
            chk(tag, $sformatf("vec%0d oe", i), pin_oe, v[23:16]);
            chk(tag, $sformatf("vec%0d out", i), pin_out, v[15:8]);
            chk("R9", $sformatf("vec%0d pull", i), pull_en, v[7:0]);
        end

        // R1 readback
        mode = 3'd7;
        bus_wr8(16'hFF0B, 8'h3E); bus_rd8(16'hFF0B, rd);
        chk("R1", "data readback", rd, 8'h3E);
        bus_wr8(16'hFE42, 8'hC1); bus_rd8(16'hFE42, rd);
        chk("R1", "pull readback", rd, 8'hC1);
        @(negedge clk);
        chk("R2", "idle rdata", bus_rdata, 8'h00);
        // R2 unreadable direction, unmapped address
        bus_rd8(16'hFE3B, rd); chk("R2", "dir read", rd, 8'hFF);
        bus_rd8(16'h1234, rd); chk("R2", "unmapped read", rd, 8'h00);

        // R3 synchronized pin read, write ignored
        pin_in = 8'h96;
        repeat (3) @(negedge clk);
        bus_rd8(16'hFFBB, rd); chk("R3", "pin read", rd, 8'h96);
        bus_wr8(16'hFFBB, 8'h00);
        bus_rd8(16'hFF0B, rd); chk("R3", "data after pin write", rd, 8'h3E);
        bus_rd8(16'hFFBB, rd); chk("R3", "pin after write", rd, 8'h96);

        // R5 manual reset keeps direction
        bus_wr8(16'hFE3B, 8'hFF); bus_wr8(16'hFF0B, 8'h5A);
        @(negedge clk); mrst_n = 1'b0;
        @(negedge clk); mrst_n = 1'b1;
        chk("R5", "oe after mrst", pin_oe, 8'hFF);
        chk("R5", "out after mrst", pin_out, 8'h00);
        bus_rd8(16'hFE42, rd); chk("R5", "pull reg after mrst", rd, 8'h00);

        // R10 hardware standby
        bus_wr8(16'hFF0B, 8'h77);
        @(negedge clk); hw_stby = 1'b1; #1;
        chk("R10", "oe in hw stby", pin_oe, 8'h00);
        chk("R10", "pull in hw stby", pull_en, 8'h00);
        bus_wr8(16'hFF0B, 8'hEE);
        @(negedge clk); hw_stby = 1'b0;
        bus_rd8(16'hFF0B, rd); chk("R10", "data after hw stby", rd, 8'h00);
        chk("R10", "oe after hw stby", pin_oe, 8'h00);

        // R11 software standby, mode 6
        mode = 3'd6;
        bus_wr8(16'hFE3B, 8'hF0); bus_wr8(16'hFE42, 8'hFF);
        @(negedge clk); addr_in = 8'hA0; sw_stby = 1'b1; keep_addr = 1'b1;
        @(negedge clk); addr_in = 8'h50; #1;
        chk("R11", "held addr", pin_out, 8'hA0);
        chk("R11", "held oe", pin_oe, 8'hF0);
        @(negedge clk);
        chk("R11", "held addr later", pin_out, 8'hA0);
        keep_addr = 1'b0; #1;
        chk("R11", "float oe", pin_oe, 8'h00);
        chk("R11", "pull inputs only", pull_en, 8'h0F);
        @(negedge clk); sw_stby = 1'b0; keep_addr = 1'b1;
        @(negedge clk);
        chk("R11", "exit live addr", pin_out, 8'h50);
        chk("R11", "exit dir kept", pin_oe, 8'hF0);

        finish_run();
    end
endmodule